// File: doc/BRIEF.md
# Ethernet Receive Ring Buffer Writer

This block sits between a byte-wide receive MAC and a circular receive buffer in system memory. Bytes of each arriving frame are copied into the ring as a record: a four-byte header (status word, then length word, both little-endian) followed by every received byte, CRC included. The next record starts at the first 4-byte boundary after the previous one's data. While the copy runs, the header holds a busy length of 0xFFF0 so that software polling the ring never mistakes a half-written record for a finished one. The true status and length are written only after the last data byte.

An address filter classifies the destination field as broadcast, multicast or an exact match against a 48-bit station address. Four accept enables and an accept-error enable decide whether a finished frame is kept. A kept frame moves the hardware write offset to the end of its record and pulses a receive-OK interrupt; a frame with error flags pulses a receive-error interrupt.

Software owns a read-pointer register that it loads with its read offset minus 16. The block adds the 16 back, reports the ring as empty when the two offsets meet, and never writes a byte into space that the host has not yet consumed. A frame that does not fit is discarded whole, with an overflow interrupt and no pointer movement.

Top module: `rx_ring_writer`

## Requirements
- R1: `cfg_ring_sel` picks a ring of 8192 << sel bytes (8K, 16K, 32K, 64K); every offset the block produces is taken modulo that size, so record data running past the end continues at offset 0.
- R2: A stored record's header word holds the status in bytes 0-1 and the length in bytes 2-3, both little-endian; the length counts every received byte including the 4-byte CRC, and data byte n sits at record offset 4+n.
- R3: On the cycle after a frame's first byte is taken, the header word is written with status 0 and length 0xFFF0; the final header is written two cycles after the last byte is taken, after all data bytes.
- R4: After a stored frame of length L, the write offset advances by (L+4) rounded up to a multiple of 4, modulo the ring size; it is always a multiple of 4.
- R5: Status bit 0 means no error flag; bits 1..5 copy `rx_err` bits 0..4 (alignment, CRC, long, runt, invalid symbol); bit 13 is broadcast (destination all ones), bit 14 is an exact station-address match, bit 15 is multicast (group bit of the first destination byte set, not broadcast); other bits are 0. The first received byte is station_addr[7:0].
- R6: `cfg_accept` bit 0 accepts every frame, bit 1 exact matches, bit 2 multicast, bit 3 broadcast; a frame matching no enabled class leaves the write offset unchanged and raises no interrupt.
- R7: A frame with any error flag pulses `irq_rer`; it is dropped unless `cfg_accept_err` is set, in which case it is stored with status bit 0 clear and no `irq_rok`.
- R8: The host register holds the read offset minus 16; the block's read offset is (register + 16) modulo the ring size, and after reset the register reads as 0xFFF0, i.e. read offset 0.
- R9: `buf_empty` is high exactly when the read offset equals the write offset.
- R10: With free space F = ring size - ((write - read) mod ring size), a byte at record offset d is written only if d < F; a frame to be kept whose rounded record size is not below F, or which lost any byte, is dropped with one `irq_ovf` pulse and the write offset unchanged.
- R11: A stored frame without errors gives exactly one `irq_rok` pulse.
- R12: Memory writes are 32-bit words addressed by word with byte enables: header writes enable all four lanes; data writes enable one lane (byte offset modulo 4) with the byte copied to all lanes. Each data byte is written on the cycle after it is taken; a new frame may start two idle cycles after the previous last byte.
- R13: After reset the write offset is 0, the ring is empty, no interrupt is raised and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_accept | input | 4 | Accept enables: all, exact match, multicast, broadcast |
| cfg_accept_err | input | 1 | Keep frames that carry error flags |
| cfg_ring_sel | input | 2 | Ring size select |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| host_rd_we | input | 1 | Load the host read-pointer register |
| host_rd_wdata | input | 16 | Read offset minus 16 |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| rx_err | input | 5 | Error flags, valid with the last byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 14 | Word address within the ring |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| wr_ptr | output | 16 | Hardware write offset |
| buf_empty | output | 1 | Read and write offsets are equal |
| irq_rok | output | 1 | Frame stored without error (pulse) |
| irq_rer | output | 1 | Frame carried error flags (pulse) |
| irq_ovf | output | 1 | Frame lost to lack of ring space (pulse) |

## Verification
Frames are sent with destinations that are the exact station address, a foreign unicast, broadcast and multicast, under accept masks that admit or refuse each class, so that every stored header's status bits and every drop are told apart by class. Lengths that are and are not multiples of four separate the alignment rounding, while error-flagged frames with the accept-error enable off and on separate dropping from storing with a cleared OK bit. Long frames with the host consuming after each one force records to straddle the ring end, and long frames with no host reads fill an 8K and then a 16K ring until overflow; the number of frames stored before the overflow tells the ring sizes apart and checks the partial writes of the lost frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int OFF_W     = 16;
    localparam int CW        = OFF_W + 1;
    localparam int WA_W      = OFF_W - 2;
    localparam int LEN_W     = 16;
    localparam int MIN_LOG2  = 13;
    localparam int ERR_W     = 5;
    localparam int DA_BYTES  = 6;
    localparam int DA_W      = 8 * DA_BYTES;
    localparam int HDR_BYTES = 4;
    localparam int SEEN_W    = $clog2(DA_BYTES + 1);
    localparam logic [LEN_W-1:0] LEN_BUSY = 16'hFFF0;
    localparam logic [OFF_W-1:0] RD_BIAS  = OFF_W'(16);

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_COPY,
        WS_FLUSH,
        WS_FIN
    } wr_state_t;

    typedef struct packed {
        logic mcast;
        logic phys;
        logic bcast;
    } addr_class_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [15:0]      status;
    } rec_hdr_t;

    function automatic logic [CW-1:0] ring_bytes(input logic [1:0] sel);
        return CW'(1) << (MIN_LOG2 + int'(sel));
    endfunction

    function automatic logic [CW-1:0] align4(input logic [CW-1:0] x);
        return (x + CW'(3)) & ~CW'(3);
    endfunction
endpackage

// File: rtl/rxr_addr_filter.sv
module rxr_addr_filter
    import rxr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            first,
    input  logic [7:0]      data,
    input  logic [DA_W-1:0] station,
    output addr_class_t     cls
);
    logic [DA_W-1:0]   da;
    logic [SEEN_W-1:0] seen;
    logic              full;

    always_ff @(posedge clk) begin
        if (rst) begin
            da   <= '0;
            seen <= '0;
        end else if (take) begin
            if (first) begin
                da[7:0] <= data;
                seen    <= SEEN_W'(1);
            end else if (seen < SEEN_W'(DA_BYTES)) begin
                da[8*int'(seen) +: 8] <= data;
                seen <= seen + SEEN_W'(1);
            end
        end
    end

    always_comb begin
        full      = (seen == SEEN_W'(DA_BYTES));
        cls.bcast = full && (da == '1);
        cls.mcast = full && da[0] && !cls.bcast;
        cls.phys  = full && (da == station);
    end
endmodule

// File: rtl/rxr_space.sv
module rxr_space
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ring_sel,
    input  logic             host_we,
    input  logic [OFF_W-1:0] host_wdata,
    input  logic [OFF_W-1:0] wr_off,
    output logic [OFF_W-1:0] ring_mask,
    output logic [CW-1:0]    free_bytes,
    output logic             empty
);
    logic [OFF_W-1:0] host_reg;
    logic [OFF_W-1:0] rd_off;
    logic [OFF_W-1:0] used;
    logic [CW-1:0]    ring;

    always_ff @(posedge clk) begin
        if (rst)          host_reg <= '0 - RD_BIAS;
        else if (host_we) host_reg <= host_wdata;
    end

    always_comb begin
        ring       = ring_bytes(ring_sel);
        ring_mask  = OFF_W'(ring - CW'(1));
        rd_off     = (host_reg + RD_BIAS) & ring_mask;
        used       = (wr_off - rd_off) & ring_mask;
        free_bytes = ring - {1'b0, used};
        empty      = (rd_off == wr_off);
    end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic [ERR_W-1:0] rx_err,
    input  logic [3:0]       cfg_accept,
    input  logic             cfg_accept_err,
    input  addr_class_t      cls,
    input  logic [CW-1:0]    free_bytes,
    input  logic [OFF_W-1:0] ring_mask,
    output logic [OFF_W-1:0] wr_off,
    output logic             mem_we,
    output logic [WA_W-1:0]  mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    output logic             irq_rok,
    output logic             irq_rer,
    output logic             irq_ovf
);
    wr_state_t        state;
    logic [OFF_W-1:0] rec;
    logic [LEN_W-1:0] cnt;
    logic [7:0]       pend;
    logic             pend_v;
    logic [CW-1:0]    pend_d;
    logic [ERR_W-1:0] err_q;
    logic             ovf_seen;

    logic [OFF_W-1:0] pend_abs;
    logic             pend_fit;
    logic             good, addr_ok, want, room;
    logic [CW-1:0]    span;
    rec_hdr_t         hdr_final;

    always_comb begin
        pend_abs  = (rec + OFF_W'(pend_d)) & ring_mask;
        pend_fit  = pend_d < free_bytes;
        good      = (err_q == '0);
        addr_ok   = cfg_accept[0]
                  | (cfg_accept[1] & cls.phys)
                  | (cfg_accept[2] & cls.mcast)
                  | (cfg_accept[3] & cls.bcast);
        want      = addr_ok && (good || cfg_accept_err);
        span      = align4(CW'(cnt) + CW'(HDR_BYTES));
        room      = !ovf_seen && (span < free_bytes);
        hdr_final.len    = cnt;
        hdr_final.status = {cls.mcast, cls.phys, cls.bcast, 7'b0, err_q, good};
    end

    always_ff @(posedge clk) begin
        mem_we  <= 1'b0;
        mem_be  <= '0;
        irq_rok <= 1'b0;
        irq_rer <= 1'b0;
        irq_ovf <= 1'b0;
        if (rst) begin
            state     <= WS_IDLE;
            rec       <= '0;
            wr_off    <= '0;
            cnt       <= '0;
            pend      <= '0;
            pend_v    <= 1'b0;
            pend_d    <= '0;
            err_q     <= '0;
            ovf_seen  <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            if (pend_v && (state == WS_COPY || state == WS_FLUSH)) begin
                pend_v <= 1'b0;
                if (pend_fit) begin
                    mem_we    <= 1'b1;
                    mem_addr  <= pend_abs[OFF_W-1:2];
                    mem_be    <= 4'b0001 << pend_abs[1:0];
                    mem_wdata <= {4{pend}};
                end else begin
                    ovf_seen <= 1'b1;
                end
            end
            case (state)
                WS_IDLE: if (rx_valid && rx_sof) begin
                    rec      <= wr_off;
                    pend     <= rx_data;
                    pend_v   <= 1'b1;
                    pend_d   <= CW'(HDR_BYTES);
                    cnt      <= LEN_W'(1);
                    err_q    <= rx_eof ? rx_err : '0;
                    ovf_seen <= !(CW'(HDR_BYTES - 1) < free_bytes);
                    if (CW'(HDR_BYTES - 1) < free_bytes) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wr_off[OFF_W-1:2];
                        mem_be    <= 4'hF;
                        mem_wdata <= {LEN_BUSY, 16'h0000};
                    end
                    state <= rx_eof ? WS_FLUSH : WS_COPY;
                end
                WS_COPY: if (rx_valid) begin
                    pend   <= rx_data;
                    pend_v <= 1'b1;
                    pend_d <= pend_d + CW'(1);
                    cnt    <= cnt + LEN_W'(1);
                    if (rx_eof) begin
                        err_q <= rx_err;
                        state <= WS_FLUSH;
                    end
                end
                WS_FLUSH: state <= WS_FIN;
                default: begin
                    irq_rer <= !good;
                    if (want) begin
                        if (room) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= rec[OFF_W-1:2];
                            mem_be    <= 4'hF;
                            mem_wdata <= hdr_final;
                            wr_off    <= (rec + OFF_W'(span)) & ring_mask;
                            irq_rok   <= good;
                        end else begin
                            irq_ovf <= 1'b1;
                        end
                    end
                    state <= WS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       cfg_accept,
    input  logic             cfg_accept_err,
    input  logic [1:0]       cfg_ring_sel,
    input  logic [DA_W-1:0]  station_addr,
    input  logic             host_rd_we,
    input  logic [OFF_W-1:0] host_rd_wdata,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic [ERR_W-1:0] rx_err,
    output logic             mem_we,
    output logic [WA_W-1:0]  mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    output logic [OFF_W-1:0] wr_ptr,
    output logic             buf_empty,
    output logic             irq_rok,
    output logic             irq_rer,
    output logic             irq_ovf
);
    addr_class_t      cls;
    logic [OFF_W-1:0] ring_mask;
    logic [CW-1:0]    free_bytes;

    rxr_addr_filter u_filt (
        .clk     (clk),
        .rst     (rst),
        .take    (rx_valid),
        .first   (rx_sof),
        .data    (rx_data),
        .station (station_addr),
        .cls     (cls)
    );

    rxr_space u_space (
        .clk        (clk),
        .rst        (rst),
        .ring_sel   (cfg_ring_sel),
        .host_we    (host_rd_we),
        .host_wdata (host_rd_wdata),
        .wr_off     (wr_ptr),
        .ring_mask  (ring_mask),
        .free_bytes (free_bytes),
        .empty      (buf_empty)
    );

    rxr_writer u_wr (
        .clk            (clk),
        .rst            (rst),
        .rx_valid       (rx_valid),
        .rx_sof         (rx_sof),
        .rx_eof         (rx_eof),
        .rx_data        (rx_data),
        .rx_err         (rx_err),
        .cfg_accept     (cfg_accept),
        .cfg_accept_err (cfg_accept_err),
        .cls            (cls),
        .free_bytes     (free_bytes),
        .ring_mask      (ring_mask),
        .wr_off         (wr_ptr),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_be         (mem_be),
        .mem_wdata      (mem_wdata),
        .irq_rok        (irq_rok),
        .irq_rer        (irq_rer),
        .irq_ovf        (irq_ovf)
    );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk
    import rxr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_ring_sel,
    input logic             host_rd_we,
    input logic [OFF_W-1:0] host_rd_wdata,
    input logic             mem_we,
    input logic [3:0]       mem_be,
    input logic [OFF_W-1:0] wr_ptr,
    input logic             buf_empty,
    input logic             irq_rok,
    input logic             irq_rer,
    input logic             irq_ovf
);
    logic [OFF_W-1:0] host_copy;
    logic [OFF_W-1:0] mask_c;

    always_ff @(posedge clk) begin
        if (rst)             host_copy <= 16'hFFF0;
        else if (host_rd_we) host_copy <= host_rd_wdata;
    end

    always_comb mask_c = OFF_W'((CW'(1) << (MIN_LOG2 + int'(cfg_ring_sel))) - CW'(1));

    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF)); // R12

    AST_WP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        wr_ptr[1:0] == 2'b00); // R4

    AST_OVF_HOLDS_WP: assert property (@(posedge clk) disable iff (rst)
        irq_ovf |-> $stable(wr_ptr)); // R10

    AST_OK_MOVES_WP: assert property (@(posedge clk) disable iff (rst)
        irq_rok |-> !$stable(wr_ptr)); // R11

    AST_OK_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        irq_rok |-> !irq_rer && !irq_ovf); // R7

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
        buf_empty == (wr_ptr == ((host_copy + OFF_W'(16)) & mask_c))); // R9
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (.*);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [3:0]  cfg_accept = 4'b1010;
    logic        cfg_accept_err = 1'b0;
    logic [1:0]  cfg_ring_sel = 2'd0;
    logic [47:0] station_addr = 48'h5A4B3C2D1E02;
    logic        host_rd_we = 1'b0;
    logic [15:0] host_rd_wdata = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [4:0]  rx_err = '0;
    logic        mem_we;
    logic [13:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [15:0] wr_ptr;
    logic        buf_empty, irq_rok, irq_rer, irq_ovf;

    rx_ring_writer u0 (.*);

    int n_chk = 0, n_err = 0;
    int ring_n = 8192, wr_m = 0, capr_m = 16'hFFF0;
    bit exp_rok, exp_rer, exp_ovf;
    int c_rok = 0, c_rer = 0, c_ovf = 0;
    int qa[$];
    int qb[$];
    logic [31:0] qd[$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rd_m();
        return (capr_m + 16) & (ring_n - 1);
    endfunction

    function automatic void push_w(input int a, input int b, input logic [31:0] d);
        qa.push_back(a); qb.push_back(b); qd.push_back(d);
    endfunction

    // every memory write is compared against the reference sequence
    always @(negedge clk) begin
        if (!rst) begin
            c_rok += int'(irq_rok); c_rer += int'(irq_rer); c_ovf += int'(irq_ovf);
            if (mem_we) begin
                if (qa.size() == 0)
                    check(0, "R10,R12 unexpected write", longint'({mem_addr, mem_be, mem_wdata}), 0);
                else begin
                    check(mem_addr == 14'(qa[0]) && mem_be == 4'(qb[0]) && mem_wdata == qd[0],
                          "R2,R3,R12 write", longint'({mem_addr, mem_be, mem_wdata}),
                          longint'({14'(qa[0]), 4'(qb[0]), qd[0]}));
                    void'(qa.pop_front()); void'(qb.pop_front()); void'(qd.pop_front());
                end
            end
        end
    end

    task automatic model_frame(ref logic [7:0] f[$], input logic [4:0] err);
        int mask, rd, used, fr, len, rec, span;
        bit ov, bc, ph, mc, aok, good, want;
        logic [47:0] da;
        logic [15:0] st;
        mask = ring_n - 1; rd = rd_m(); used = (wr_m - rd) & mask; fr = ring_n - used;
        len = f.size(); rec = wr_m;
        ov = !(3 < fr);
        if (!ov) push_w(rec >> 2, 15, 32'hFFF00000);
        for (int i = 0; i < len; i++) begin
            int d = 4 + i;
            if (d < fr) push_w(((rec + d) & mask) >> 2, 1 << (d & 3), {4{f[i]}});
            else ov = 1;
        end
        da = '0;
        for (int i = 0; i < 6 && i < len; i++) da[8*i +: 8] = f[i];
        bc = (len >= 6) && (da == 48'hFFFFFFFFFFFF);
        ph = (len >= 6) && (da == station_addr);
        mc = (len >= 6) && da[0] && !bc;
        good = (err == 0);
        aok = cfg_accept[0] || (cfg_accept[1] && ph) || (cfg_accept[2] && mc) || (cfg_accept[3] && bc);
        want = aok && (good || cfg_accept_err);
        span = (4 + len + 3) & ~3;
        st = {mc, ph, bc, 7'b0, err, good};
        exp_rer = !good; exp_rok = 0; exp_ovf = 0;
        if (want) begin
            if (!ov && span < fr) begin
                push_w(rec >> 2, 15, {len[15:0], st});
                wr_m = (rec + span) & mask;
                exp_rok = good;
            end else exp_ovf = 1;
        end
    endtask

    task automatic build(ref logic [7:0] f[$], input logic [47:0] da, input int len, input int seed);
        f.delete();
        for (int i = 0; i < len; i++) begin
            if (i < 6) f.push_back(da[8*i +: 8]);
            else f.push_back(8'((i * 7 + seed) & 255));
        end
    endtask

    task automatic send(ref logic [7:0] f[$], input logic [4:0] err, input string tag);
        model_frame(f, err);
        c_rok = 0; c_rer = 0; c_ovf = 0;
        for (int i = 0; i < f.size(); i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == f.size() - 1);
            rx_data = f[i]; rx_err = rx_eof ? err : 5'd0;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
        repeat (3) @(negedge clk);
        check(c_rok == int'(exp_rok), {tag, " R11 irq_rok"}, c_rok, exp_rok);
        check(c_rer == int'(exp_rer), {tag, " R7 irq_rer"}, c_rer, exp_rer);
        check(c_ovf == int'(exp_ovf), {tag, " R10 irq_ovf"}, c_ovf, exp_ovf);
        check(wr_ptr == 16'(wr_m), {tag, " R4,R6 wr_ptr"}, wr_ptr, wr_m);
        check(buf_empty == (wr_m == rd_m()), {tag, " R9 buf_empty"}, buf_empty, wr_m == rd_m());
    endtask

    task automatic set_rd(input int real_off);
        @(negedge clk);
        host_rd_we = 1; host_rd_wdata = 16'(real_off - 16);
        @(negedge clk);
        host_rd_we = 0;
        capr_m = (real_off - 16) & 16'hFFFF;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst = 1; cfg_ring_sel = sel;
        repeat (3) @(negedge clk);
        rst = 0;
        ring_n = 8192 << sel; wr_m = 0; capr_m = 16'hFFF0;
        @(negedge clk);
        check(wr_ptr == 0, "R13 wr_ptr after reset", wr_ptr, 0);
        check(buf_empty == 1, "R13,R8 empty after reset", buf_empty, 1);
        check({irq_rok, irq_rer, irq_ovf, mem_we} == 4'b0, "R13 quiet after reset",
              {irq_rok, irq_rer, irq_ovf, mem_we}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] f[$];
        logic [47:0] foreign;
        logic [47:0] mcast;
        int prev, stored;
        bit wrapped;
        foreign = 48'h665544332210;
        mcast = 48'h0000005E0001;

        do_reset(2'd0);
        // R2 R5 exact match, length a multiple of 4
        build(f, station_addr, 64, 1);  send(f, 5'd0, "R2 unicast 64");
        // R4 length 61 rounds the record up
        build(f, station_addr, 61, 2);  send(f, 5'd0, "R4 unicast 61");
        build(f, 48'hFFFFFFFFFFFF, 70, 3); send(f, 5'd0, "R5 broadcast");
        cfg_accept = 4'b0010;
        build(f, 48'hFFFFFFFFFFFF, 70, 4); send(f, 5'd0, "R6 broadcast refused");
        build(f, mcast, 66, 5);         send(f, 5'd0, "R6 multicast refused");
        cfg_accept = 4'b0110;
        build(f, mcast, 66, 6);         send(f, 5'd0, "R5 multicast kept");
        build(f, foreign, 60, 7);       send(f, 5'd0, "R6 foreign refused");
        cfg_accept = 4'b0001;
        build(f, foreign, 63, 8);       send(f, 5'd0, "R6 accept all");
        cfg_accept = 4'b1010;
        build(f, station_addr, 64, 9);  send(f, 5'b00010, "R7 crc dropped");
        cfg_accept_err = 1;
        build(f, station_addr, 65, 10); send(f, 5'b10001, "R7 error kept");
        cfg_accept_err = 0;
        // R8 biased read pointer: consume everything
        set_rd(wr_m);
        check(buf_empty == 1, "R8,R9 host caught up", buf_empty, 1);

        // R1 records straddle the end of an 8K ring
        wrapped = 0;
        for (int k = 0; k < 8; k++) begin
            prev = wr_ptr;
            build(f, station_addr, 1500, 20 + k); send(f, 5'd0, "R1 wrap");
            if (wr_ptr < 16'(prev)) wrapped = 1;
            set_rd(wr_m);
        end
        check(wrapped, "R1 write offset wrapped", wrapped, 1);

        // R10 fill the 8K ring without host reads
        stored = 0;
        for (int k = 0; k < 12; k++) begin
            build(f, station_addr, 1000, 40 + k); send(f, 5'd0, "R10 fill 8K");
            if (exp_ovf) break;
            stored++;
        end
        check(stored == 8, "R1,R10 frames stored in 8K", stored, 8);
        set_rd(wr_m);
        build(f, station_addr, 100, 60); send(f, 5'd0, "R10 after drain");

        // R1 a 16K ring holds twice as many
        do_reset(2'd1);
        stored = 0;
        for (int k = 0; k < 20; k++) begin
            build(f, station_addr, 1000, 70 + k); send(f, 5'd0, "R10 fill 16K");
            if (exp_ovf) break;
            stored++;
        end
        check(stored == 16, "R1,R10 frames stored in 16K", stored, 16);
        repeat (4) @(negedge clk);
        check(qa.size() == 0, "R3,R12 all writes seen", qa.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule